// File: doc/BRIEF.md
# Wide Free-Running Timer with Narrow Compare

This block is a system timer. A wide count register advances by one on every timer tick and wraps from all ones back to zero without stopping. Next to it sits a compare register that is narrower than the count. When a tick carries the low bits of the count onto the compare value, the block sends a one-cycle set request for a fixed interrupt vector to the interrupt controller.

Because the compare covers only the low field of the count, a given compare value matches once on every wrap of that field. Software can read the count, and can read and write the compare value, through a small register port. The read data is selected combinationally by the address. A write to the count is dropped, so the count is read-only. By default the count is 52 bits wide, the compare is 24 bits wide and the vector is number 50. The tick strobe comes from outside the block; in the intended system one tick lasts 80 ns.

Top module: `tmr_timer`

## Requirements
- R1: A synchronous reset clears the count and the compare value to zero and holds the set-request word at zero.
- R2: In each clock cycle where `tick` is high, the count increases by exactly one. In a cycle without a tick, it holds its value.
- R3: The count wraps from all ones to zero on the next tick and keeps counting.
- R4: The set-request word is high for exactly one cycle, with only bit `IRQ_VEC` set, in the cycle after a tick edge that moved the count to a value whose low `CMP_W` bits equal the compare value. In every other cycle the word is zero.
- R5: A compare value that is not changed fires once per `2**CMP_W` ticks.
- R6: No request is raised while the count holds without ticking, even when its low bits equal the compare value. Writing a compare value equal to the current low count bits raises no request by itself.
- R7: A compare write can be read back in the next cycle and first governs the tick that follows the write cycle. A tick in the same cycle as the write is matched against the old compare value.
- R8: A read at offset `CNT_OFS` returns the count zero-extended to 64 bits; every bit above `CNT_W-1` reads as zero.
- R9: A write to offset `CNT_OFS` leaves the count unchanged.
- R10: A compare write keeps only write-data bits `[CMP_W-1:0]` and drops the rest. A read at `CMP_OFS` returns the compare value zero-extended. A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick strobe; one cycle high per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset for reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| irq_set | output | NUM_VEC | One-hot set request to the interrupt controller |

## Verification
The bench builds the timer with a 12-bit count and a 6-bit compare, while keeping the 64-bit data path, the 64 vectors, vector 50 and both register offsets. With these widths a full wrap of the compare field takes 64 ticks and a full wrap of the count takes 4096 ticks. That puts the recurrence of a match and the count rollover within a short directed run. The narrow count also checks that the zero-extended read clears every bit above the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_COUNT   = 2'd1,
        SEL_COMPARE = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     we;
        reg_sel_e sel;
    } reg_req_t;

    function automatic reg_sel_e decode_addr(
        input logic [31:0] a,
        input logic [31:0] cnt_ofs,
        input logic [31:0] cmp_ofs
    );
        if (a == cnt_ofs)      return SEL_COUNT;
        else if (a == cmp_ofs) return SEL_COMPARE;
        else                   return SEL_NONE;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    assign cnt_nxt = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int CMP_W   = 24,
    parameter int NUM_VEC = 64,
    parameter int IRQ_VEC = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [CMP_W-1:0]   cnt_low_nxt,
    input  logic               cmp_we,
    input  logic [CMP_W-1:0]   cmp_wdata,
    output logic [CMP_W-1:0]   cmp_q,
    output logic [NUM_VEC-1:0] irq_set
);
    logic hit;
    logic hit_q;

    // the compare register's pre-edge value is used, so a write in this
    // cycle governs only later ticks
    assign hit = tick && (cnt_low_nxt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit;
            if (cmp_we) cmp_q <= cmp_wdata;
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        if (v == IRQ_VEC) begin : g_on
            assign irq_set[v] = hit_q;
        end else begin : g_off
            assign irq_set[v] = 1'b0;
        end
    end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int          ADDR_W  = 20,
    parameter int          DATA_W  = 64,
    parameter int          CNT_W   = 52,
    parameter int          CMP_W   = 24,
    parameter logic [31:0] CNT_OFS = 32'h0002_0000,
    parameter logic [31:0] CMP_OFS = 32'h0003_0000
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CMP_W-1:0]  cmp_val,
    output logic              cmp_we,
    output logic [CMP_W-1:0]  cmp_wdata,
    output logic [DATA_W-1:0] rd_data
);
    reg_req_t req;

    always_comb begin
        req.sel = decode_addr(32'(addr), CNT_OFS, CMP_OFS);
        req.we  = wr_en;
    end

    // writes to the count slot fall through: the count is read-only
    assign cmp_we    = req.we && (req.sel == SEL_COMPARE);
    assign cmp_wdata = wr_data[CMP_W-1:0];

    always_comb begin
        unique case (req.sel)
            SEL_COUNT:   rd_data = DATA_W'(cnt_val);
            SEL_COMPARE: rd_data = DATA_W'(cmp_val);
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_timer.sv
module tmr_timer #(
    parameter int          ADDR_W  = 20,
    parameter int          DATA_W  = 64,
    parameter int          CNT_W   = 52,
    parameter int          CMP_W   = 24,
    parameter int          NUM_VEC = 64,
    parameter int          IRQ_VEC = 50,
    parameter logic [31:0] CNT_OFS = 32'h0002_0000,
    parameter logic [31:0] CMP_OFS = 32'h0003_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_VEC-1:0] irq_set
);
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CMP_W-1:0] cmp_val;
    logic [CMP_W-1:0] cmp_wdata;
    logic             cmp_we;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt_q   (cnt_val),
        .cnt_nxt (cnt_nxt)
    );

    tmr_match #(
        .CMP_W   (CMP_W),
        .NUM_VEC (NUM_VEC),
        .IRQ_VEC (IRQ_VEC)
    ) u_match (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .cnt_low_nxt (cnt_nxt[CMP_W-1:0]),
        .cmp_we      (cmp_we),
        .cmp_wdata   (cmp_wdata),
        .cmp_q       (cmp_val),
        .irq_set     (irq_set)
    );

    tmr_regif #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .CMP_W   (CMP_W),
        .CNT_OFS (CNT_OFS),
        .CMP_OFS (CMP_OFS)
    ) u_regif (
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .cnt_val   (cnt_val),
        .cmp_val   (cmp_val),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W   = 52,
    parameter int CMP_W   = 24,
    parameter int NUM_VEC = 64,
    parameter int IRQ_VEC = 50
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic [CNT_W-1:0]   cnt,
    input logic [CMP_W-1:0]   cmp,
    input logic [NUM_VEC-1:0] irq_set
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (cnt == '0 && cmp == '0 && irq_set == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == '1) |=> cnt == '0);

    assert_irq_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        irq_set != '0 |-> ($countones(irq_set) == 1 && irq_set[IRQ_VEC]));

    assert_irq_on_match_R4: assert property (@(posedge clk) disable iff (rst)
        irq_set != '0 |-> cnt[CMP_W-1:0] == $past(cmp));

    assert_no_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> irq_set == '0);
endmodule

bind tmr_timer tmr_checker #(
    .CNT_W   (CNT_W),
    .CMP_W   (CMP_W),
    .NUM_VEC (NUM_VEC),
    .IRQ_VEC (IRQ_VEC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (cnt_val),
    .cmp     (cmp_val),
    .irq_set (irq_set)
);

// File: tb/sim_tmr_timer.sv
module sim_tmr_timer;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W  = 20;
    localparam int          DATA_W  = 64;
    localparam int          CNT_W   = 12;
    localparam int          CMP_W   = 6;
    localparam int          NUM_VEC = 64;
    localparam int          IRQ_VEC = 50;
    localparam logic [31:0] CNT_OFS = 32'h0002_0000;
    localparam logic [31:0] CMP_OFS = 32'h0003_0000;
    localparam logic [ADDR_W-1:0] A_CNT = CNT_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CMP = CMP_OFS[ADDR_W-1:0];
    localparam logic [NUM_VEC-1:0] IRQ_WORD = NUM_VEC'(1) << IRQ_VEC;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [DATA_W-1:0]  rd_data;
    logic [NUM_VEC-1:0] irq_set;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    logic [CNT_W-1:0] exp_cnt = '0;
    logic [CMP_W-1:0] exp_cmp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_timer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CMP_W(CMP_W),
        .NUM_VEC(NUM_VEC), .IRQ_VEC(IRQ_VEC), .CNT_OFS(CNT_OFS), .CMP_OFS(CMP_OFS)
    ) u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_set(irq_set)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // one clock cycle with the given inputs; checks the request word (R4)
    task automatic step(input logic t, input logic w, input logic [ADDR_W-1:0] a, input logic [63:0] d);
        logic [CNT_W-1:0] nx;
        logic hit;
        nx  = exp_cnt + CNT_W'(1);
        hit = t && (nx[CMP_W-1:0] == exp_cmp);
        tick = t; wr_en = w; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        if (t) exp_cnt = nx;
        if (w && a == A_CMP) exp_cmp = d[CMP_W-1:0];
        chk(irq_set == (hit ? IRQ_WORD : '0), "R4 request word", 64'(irq_set), 64'(hit ? IRQ_WORD : '0));
        if (irq_set != '0) irq_seen++;
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(A_CNT, v); chk(v == 0, "R1 count after reset", v, 0);
        rd(A_CMP, v); chk(v == 0, "R1 compare after reset", v, 0);
        chk(irq_set == '0, "R1 request after reset", 64'(irq_set), 0);
    endtask

    task automatic t_count();
        logic [63:0] v;
        for (int i = 0; i < 5; i++) step(1, 0, A_CNT, 0);
        rd(A_CNT, v); chk(v == 5, "R2 count after ticks", v, 5);
        for (int i = 0; i < 3; i++) step(0, 0, A_CNT, 0);
        rd(A_CNT, v); chk(v == 5, "R2 count holds", v, 5);
    endtask

    task automatic t_cmp_rw();
        logic [63:0] v;
        step(0, 1, A_CMP, 64'hABCDE7);
        rd(A_CMP, v); chk(v == 64'h27, "R10 compare truncated readback", v, 64'h27);
        rd(20'h10000, v); chk(v == 0, "R10 unmapped read", v, 0);
    endtask

    task automatic t_match();
        int s0;
        step(0, 1, A_CMP, 64'd9);
        s0 = irq_seen;
        for (int i = 0; i < 4; i++) step(1, 0, A_CNT, 0);
        chk(irq_seen - s0 == 1, "R4 one request at match", 64'(irq_seen - s0), 1);
        step(0, 0, A_CNT, 0);
        chk(irq_set == '0, "R4 request lasts one cycle", 64'(irq_set), 0);
    endtask

    task automatic t_recur();
        int s0;
        logic [63:0] v;
        s0 = irq_seen;
        for (int i = 0; i < 64; i++) step(1, 0, A_CNT, 0);
        chk(irq_seen - s0 == 1, "R5 one request per field wrap", 64'(irq_seen - s0), 1);
        rd(A_CNT, v); chk(v == 73, "R5 count after wrap of field", v, 73);
    endtask

    task automatic t_hold();
        int s0;
        s0 = irq_seen;
        for (int i = 0; i < 3; i++) step(0, 0, A_CNT, 0);
        step(1, 0, A_CNT, 0);
        step(0, 1, A_CMP, 64'd10);
        step(0, 0, A_CNT, 0);
        chk(irq_seen == s0, "R6 no request without tick", 64'(irq_seen - s0), 0);
    endtask

    task automatic t_same_cycle();
        int s0;
        logic [63:0] v;
        step(0, 1, A_CMP, 64'd11);
        s0 = irq_seen;
        step(1, 1, A_CMP, 64'd20);
        chk(irq_seen - s0 == 1, "R7 tick with write uses old compare", 64'(irq_seen - s0), 1);
        rd(A_CMP, v); chk(v == 20, "R7 readback next cycle", v, 20);
        step(1, 1, A_CMP, 64'd13);
        step(1, 0, A_CNT, 0);
        chk(irq_seen - s0 == 2, "R7 new compare on later tick", 64'(irq_seen - s0), 2);
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        int n;
        n = int'((1 << CNT_W) - 1) - int'(exp_cnt);
        for (int i = 0; i < n; i++) step(1, 0, A_CNT, 0);
        rd(A_CNT, v); chk(v == 64'hFFF, "R8 count zero-extended", v, 64'hFFF);
        step(1, 0, A_CNT, 0);
        rd(A_CNT, v); chk(v == 0, "R3 count wraps to zero", v, 0);
    endtask

    task automatic t_ignore();
        logic [63:0] v;
        step(0, 1, A_CNT, '1);
        rd(A_CNT, v); chk(v == 0, "R9 count write ignored", v, 0);
        step(1, 1, A_CNT, '1);
        rd(A_CNT, v); chk(v == 1, "R9 count write with tick ignored", v, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_cmp_rw();
        t_match();
        t_recur();
        t_hold();
        t_same_cycle();
        t_wrap();
        t_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule